// File: doc/BRIEF.md
# Bit-Matrix Rotation Scrambler

The block takes a stream of bytes in groups of eight and stacks each group into an 8x8 array of bit cells, one byte per row. It then scrambles the array in two passes: every row is circularly rotated by its own amount and direction, and then every column is rotated the same way. A 17-bit control word, sampled with the first byte of each group, supplies all sixteen directions and amounts. A mode input picks encryption or decryption. Decryption runs the column pass first and the row pass second, with every direction flipped, so it exactly undoes encryption under the same control word.

Each cell is a flip-flop behind a multiplexer that picks hold, external load, or one of its four neighbours. A rotation of length r is r single-position steps. Every line steps on each cycle while the pass counter is below its amount, so all rows, or all columns, finish within one fixed 8-cycle pass. A group therefore occupies 24 cycles: 8 loads and two 8-cycle passes. The scrambled bytes of one group leave the block while the next group is loaded, one output byte per input byte. The last group is therefore flushed by sending a further group.

Back-pressure rules: a byte is accepted when `in_valid` and `in_ready` are both high. While a result is held, an output byte moves only together with an input byte. `out_valid` then needs `in_valid`, `in_ready` needs `out_ready`, and both transfers happen on the same edge. During the two rotation passes `in_ready` and `out_valid` are low.

Top module: `bitrot_cipher`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `in_ready` is high and `out_valid` is low.
- R2: The x-th accepted byte of a group (x = 0..7) fills row x, and bit y of that byte goes to column y. With an all-zero control word in encrypt mode the group comes out unchanged.
- R3: A row with direction bit 1 is rotated left by r: afterwards bit y holds the former bit (y+r) mod 8. With direction bit 0 it is rotated right: bit y holds the former bit (y-r) mod 8.
- R4: A column with direction bit 1 is rotated up by s: afterwards row x holds the former row (x+s) mod 8 in that column. With direction bit 0 it is rotated down: row x holds the former row (x-s) mod 8.
- R5: Control word mapping: line k takes its direction from bit k mod 17 and its 3-bit amount from bits (k+1), (k+2), (k+3) mod 17, least significant first. Rows use k = 0..7. Column j uses k = j+8.
- R6: With `decrypt` = 0 the row pass runs before the column pass. With `decrypt` = 1 the column pass runs first, then the row pass, each with its direction bits inverted. Decrypting a ciphertext under the same control word returns the plaintext.
- R7: The control word and `decrypt` are sampled with the first byte of a group. Changing them during bytes 1..7 has no effect on that group's result.
- R8: After the eighth byte of a group is accepted, `in_ready` stays low for exactly 16 cycles.
- R9: A result is emitted row 0 first. Each output byte transfers on the same edge as one input byte of the next group. `out_valid` is high only when a result is held, the block is loading and `in_valid` is high.
- R10: While a result is held and `out_ready` is low, `in_ready` is low and `out_data` stays stable.
- R11: Before the first group has been scrambled, `out_valid` stays low and input is accepted regardless of `out_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte can be taken |
| in_data | input | 8 | Input byte |
| key_bits | input | 17 | Rotation control word, sampled with byte 0 |
| decrypt | input | 1 | 1 selects decryption, sampled with byte 0 |
| out_valid | output | 1 | Scrambled byte present |
| out_ready | input | 1 | Sink can take the scrambled byte |
| out_data | output | 8 | Scrambled byte, row 0 first |

## Verification
The assertions assume the source never lets `in_valid` go unknown and does not expect output to drain without new input. They also assume a group is a run of exactly eight accepted bytes counted from reset. The directed stimulus always sends whole groups and only lowers `out_ready` while `in_valid` is held high. It ends with a trailing group so that every result is flushed and compared.

// File: rtl/bitrot_pkg.sv
`timescale 1ns/1ps
package bitrot_pkg;

  // Source selection for one bit cell.
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,  // keep value
    OP_EXT   = 3'd1,  // take the external load bit
    OP_ROT_L = 3'd2,  // take the neighbour at column y+1
    OP_ROT_R = 3'd3,  // take the neighbour at column y-1
    OP_ROT_U = 3'd4,  // take the neighbour at row x+1
    OP_ROT_D = 3'd5   // take the neighbour at row x-1
  } cell_op_e;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_PASS1 = 2'd1,
    ST_PASS2 = 2'd2
  } phase_e;

endpackage

// File: rtl/bitrot_cell.sv
`timescale 1ns/1ps
module bitrot_cell
  import bitrot_pkg::*;
(
  input  logic     clk,
  input  cell_op_e op,
  input  logic     ext_bit,
  input  logic     nb_ylo,   // cell at column y-1
  input  logic     nb_yhi,   // cell at column y+1
  input  logic     nb_xlo,   // cell at row x-1
  input  logic     nb_xhi,   // cell at row x+1
  output logic     q
);

  always_ff @(posedge clk) begin
    unique case (op)
      OP_EXT:   q <= ext_bit;
      OP_ROT_L: q <= nb_yhi;
      OP_ROT_R: q <= nb_ylo;
      OP_ROT_U: q <= nb_xhi;
      OP_ROT_D: q <= nb_xlo;
      default:  q <= q;
    endcase
  end

endmodule

// File: rtl/bitrot_array.sv
`timescale 1ns/1ps
module bitrot_array
  import bitrot_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           load_shift,
  input  logic           row_en,
  input  logic           col_en,
  input  cell_op_e       row_op [N],
  input  cell_op_e       col_op [N],
  input  logic [N-1:0]   ext_byte,
  output logic [N-1:0]   head_row
);

  logic [N-1:0][N-1:0] grid;  // grid[row][col]

  for (genvar x = 0; x < N; x++) begin : g_row
    localparam int XHI = (x + 1) % N;
    localparam int XLO = (x + N - 1) % N;
    for (genvar y = 0; y < N; y++) begin : g_col
      localparam int YHI = (y + 1) % N;
      localparam int YLO = (y + N - 1) % N;
      cell_op_e op;

      // Loading reuses the upward path: bytes climb toward row 0 and the
      // bottom row takes the new byte.
      always_comb begin
        if (load_shift)  op = (x == N - 1) ? OP_EXT : OP_ROT_U;
        else if (row_en) op = row_op[x];
        else if (col_en) op = col_op[y];
        else             op = OP_HOLD;
      end

      bitrot_cell u_cell (
        .clk     (clk),
        .op      (op),
        .ext_bit (ext_byte[y]),
        .nb_ylo  (grid[x][YLO]),
        .nb_yhi  (grid[x][YHI]),
        .nb_xlo  (grid[XLO][y]),
        .nb_xhi  (grid[XHI][y]),
        .q       (grid[x][y])
      );
    end
  end

  assign head_row = grid[0];

endmodule

// File: rtl/bitrot_ctrl.sv
`timescale 1ns/1ps
module bitrot_ctrl
  import bitrot_pkg::*;
#(
  parameter int N     = 8,
  parameter int KEY_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic [KEY_W-1:0] key_bits,
  input  logic             decrypt,
  output logic             in_ready,
  output logic             out_valid,
  output logic             load_shift,
  output logic             row_en,
  output logic             col_en,
  output cell_op_e         row_op [N],
  output cell_op_e         col_op [N]
);

  localparam int AMT_W = $clog2(N);
  localparam logic [AMT_W-1:0] LAST = AMT_W'(N - 1);

  phase_e           st;
  logic [AMT_W-1:0] cnt;
  logic             have_out;
  logic [KEY_W-1:0] key_q;
  logic             dec_q;
  logic             in_fire;

  assign in_ready   = (st == ST_LOAD) && (!have_out || out_ready);
  assign out_valid  = (st == ST_LOAD) && have_out && in_valid;
  assign in_fire    = in_valid && in_ready;
  assign load_shift = in_fire;

  // Pass order depends on the sampled mode.
  assign row_en = (st == ST_PASS1 && !dec_q) || (st == ST_PASS2 && dec_q);
  assign col_en = (st == ST_PASS1 && dec_q)  || (st == ST_PASS2 && !dec_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_LOAD;
      cnt      <= '0;
      have_out <= 1'b0;
      key_q    <= '0;
      dec_q    <= 1'b0;
    end else begin
      unique case (st)
        ST_LOAD: begin
          if (in_fire) begin
            if (cnt == '0) begin
              key_q <= key_bits;
              dec_q <= decrypt;
            end
            if (cnt == LAST) begin
              cnt      <= '0;
              st       <= ST_PASS1;
              have_out <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_PASS1: begin
          if (cnt == LAST) begin
            cnt <= '0;
            st  <= ST_PASS2;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PASS2: begin
          if (cnt == LAST) begin
            cnt      <= '0;
            st       <= ST_LOAD;
            have_out <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_LOAD;
      endcase
    end
  end

  // Per-line parameters from a sliding window over the control word.
  for (genvar k = 0; k < N; k++) begin : g_line
    logic [AMT_W-1:0] r_amt;
    logic [AMT_W-1:0] c_amt;
    logic             r_dir;
    logic             c_dir;

    for (genvar b = 0; b < AMT_W; b++) begin : g_bit
      assign r_amt[b] = key_q[(k + 1 + b) % KEY_W];
      assign c_amt[b] = key_q[(k + N + 1 + b) % KEY_W];
    end

    assign r_dir = key_q[k % KEY_W] ^ dec_q;
    assign c_dir = key_q[(k + N) % KEY_W] ^ dec_q;

    always_comb begin
      row_op[k] = OP_HOLD;
      if (row_en && (cnt < r_amt)) row_op[k] = r_dir ? OP_ROT_L : OP_ROT_R;
    end

    always_comb begin
      col_op[k] = OP_HOLD;
      if (col_en && (cnt < c_amt)) col_op[k] = c_dir ? OP_ROT_U : OP_ROT_D;
    end
  end

endmodule

// File: rtl/bitrot_cipher.sv
`timescale 1ns/1ps
module bitrot_cipher
  import bitrot_pkg::*;
#(
  parameter int N     = 8,
  parameter int KEY_W = 2 * N + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [N-1:0]     in_data,
  input  logic [KEY_W-1:0] key_bits,
  input  logic             decrypt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [N-1:0]     out_data
);

  logic     load_shift;
  logic     row_en;
  logic     col_en;
  cell_op_e row_op [N];
  cell_op_e col_op [N];

  bitrot_ctrl #(.N(N), .KEY_W(KEY_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .key_bits   (key_bits),
    .decrypt    (decrypt),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .load_shift (load_shift),
    .row_en     (row_en),
    .col_en     (col_en),
    .row_op     (row_op),
    .col_op     (col_op)
  );

  bitrot_array #(.N(N)) u_array (
    .clk        (clk),
    .load_shift (load_shift),
    .row_en     (row_en),
    .col_en     (col_en),
    .row_op     (row_op),
    .col_op     (col_op),
    .ext_byte   (in_data),
    .head_row   (out_data)
  );

endmodule

// File: rtl/bitrot_cipher_chk.sv
`timescale 1ns/1ps
module bitrot_cipher_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [N-1:0] out_data
);

  localparam int NB_W = $clog2(N);
  localparam int BZ_W = $clog2(2 * N + 1);

  logic [NB_W-1:0] nbytes;
  logic [BZ_W-1:0] busy;
  logic            seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbytes <= '0;
      busy   <= '0;
      seen   <= 1'b0;
    end else begin
      if (busy != '0) busy <= busy - 1'b1;
      if (in_valid && in_ready) begin
        if (nbytes == NB_W'(N - 1)) begin
          nbytes <= '0;
          busy   <= BZ_W'(2 * N);
          seen   <= 1'b1;
        end else begin
          nbytes <= nbytes + 1'b1;
        end
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (in_ready && !out_valid));

  assert_busy_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy != '0) |-> !in_ready);

  assert_out_needs_in_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);

  assert_paired_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> in_ready);

  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));

  assert_no_early_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !out_valid);

endmodule

bind bitrot_cipher bitrot_cipher_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/bitrot_cipher_tb.sv
`timescale 1ns/1ps
module bitrot_cipher_tb;

  typedef logic [7:0] grp_t [8];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic [16:0] key_bits = '0;
  logic        decrypt = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;

  grp_t  pend;
  bit    pend_ok = 1'b0;
  string pend_tag = "";

  always #4 clk = ~clk;

  bitrot_cipher u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .key_bits  (key_bits),
    .decrypt   (decrypt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---- reference model built from the requirements ----
  function automatic void do_rows(inout grp_t m, input logic [16:0] k, input bit inv);
    grp_t o;
    o = m;
    for (int x = 0; x < 8; x++) begin
      bit p;
      int r;
      p = k[x % 17] ^ inv;
      r = 4 * k[(x + 3) % 17] + 2 * k[(x + 2) % 17] + k[(x + 1) % 17];
      for (int y = 0; y < 8; y++)
        m[x][y] = p ? o[x][(y + r) % 8] : o[x][(y + 8 - r) % 8];
    end
  endfunction

  function automatic void do_cols(inout grp_t m, input logic [16:0] k, input bit inv);
    grp_t o;
    o = m;
    for (int j = 0; j < 8; j++) begin
      bit q;
      int s;
      q = k[(j + 8) % 17] ^ inv;
      s = 4 * k[(j + 11) % 17] + 2 * k[(j + 10) % 17] + k[(j + 9) % 17];
      for (int x = 0; x < 8; x++)
        m[x][j] = q ? o[(x + s) % 8][j] : o[(x + 8 - s) % 8][j];
    end
  endfunction

  function automatic void model(input grp_t p, input logic [16:0] k, input bit dec,
                                output grp_t c);
    grp_t m;
    m = p;
    if (!dec) begin
      do_rows(m, k, 1'b0);
      do_cols(m, k, 1'b0);
    end else begin
      do_cols(m, k, 1'b1);
      do_rows(m, k, 1'b1);
    end
    c = m;
  endfunction

  function automatic void make_group(input int seed, output grp_t g);
    for (int i = 0; i < 8; i++)
      g[i] = 8'((seed * 37 + i * 91 + (seed ^ i) * 13) ^ (i << 4));
  endfunction

  // Sends one group; compares the previous result streamed out meanwhile.
  // scramble: after byte 0 the control word and mode are disturbed (R7).
  // stall_at: byte index at which out_ready is pulled low for 4 cycles (R10).
  task automatic send_group(input grp_t din, input logic [16:0] k, input bit dec,
                            input bit scramble, input int stall_at);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = din[b];
      key_bits = (b == 0 || !scramble) ? k : (k ^ 17'(32'h1ABCD * b));
      decrypt  = (b == 0 || !scramble) ? dec : ~dec;
      if (b == stall_at && pend_ok) begin
        out_ready = 1'b0;
        for (int c = 0; c < 4; c++) begin
          #1;
          check(in_ready == 1'b0, "R10 in_ready low during stall", int'(in_ready), 0);
          check(out_data == pend[b], "R10 out_data held during stall", int'(out_data), int'(pend[b]));
          @(negedge clk);
        end
        out_ready = 1'b1;
      end
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      if (pend_ok) begin
        check(out_valid == 1'b1, {pend_tag, " R9 out_valid with input"}, int'(out_valid), 1);
        check(out_data == pend[b], {pend_tag, " R9 result byte"}, int'(out_data), int'(pend[b]));
      end else begin
        check(out_valid == 1'b0, "R11 no output before first result", int'(out_valid), 0);
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    begin
      int n;
      n = 0;
      while (!in_ready && n < 100) begin
        n++;
        @(negedge clk);
      end
      check(n == 16, "R8 busy cycles after eighth byte", n, 16);
    end
  endtask

  task automatic t_reset;
    #1;
    check(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
  endtask

  // R2 / R11: identity key, first group, accepted even with out_ready low.
  task automatic t_identity(input grp_t p);
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    check(in_ready == 1'b1, "R11 in_ready ignores out_ready", int'(in_ready), 1);
    out_ready = 1'b1;
    send_group(p, 17'h0, 1'b0, 1'b0, -1);
    pend = p; pend_ok = 1'b1; pend_tag = "R2";
  endtask

  task automatic t_group(input grp_t p, input logic [16:0] k, input bit dec,
                         input bit scramble, input int stall_at, input string tag);
    grp_t c;
    send_group(p, k, dec, scramble, stall_at);
    model(p, k, dec, c);
    pend = c; pend_ok = 1'b1; pend_tag = tag;
  endtask

  initial begin : watchdog
    #(8 * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    grp_t g1, g2, g3, g4, g6, g7, g8, c4;
    make_group(1, g1);
    make_group(2, g2);
    make_group(3, g3);
    make_group(4, g4);
    make_group(6, g6);
    make_group(7, g7);
    make_group(8, g8);

    t_reset();
    t_identity(g1);
    // R3: only row fields non-zero (bits 2..7)
    t_group(g2, 17'h000FC, 1'b0, 1'b0, -1, "R3");
    // R4: only column fields non-zero (bits 11..16)
    t_group(g3, 17'h1F800, 1'b0, 1'b0, -1, "R4");
    // R5: mixed word, with a stall while the R4 result drains (R10)
    t_group(g4, 17'h0B5A3, 1'b0, 1'b0, 3, "R5");
    model(g4, 17'h0B5A3, 1'b0, c4);
    // R6: decrypt the ciphertext; expected result is the plaintext itself
    send_group(c4, 17'h0B5A3, 1'b1, 1'b0, -1);
    pend = g4; pend_ok = 1'b1; pend_tag = "R6 roundtrip";
    // R7: control word and mode disturbed after byte 0
    t_group(g6, 17'h1369D, 1'b0, 1'b1, -1, "R7");
    // R6: decrypt order on a fresh group, with stall at the first byte
    t_group(g7, 17'h1369D, 1'b1, 1'b0, 0, "R6 decrypt");
    // flush
    t_group(g8, 17'h05555, 1'b0, 1'b0, 7, "R5 flush");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule